// File: doc/BRIEF.md
# Block Coefficient Run-Length Tokenizer

This block turns the quantized transform coefficients of 8x8 blocks into fixed-length run-length tokens that a later stage stores in memory and reads back to build a variable-length bitstream. Coefficients arrive one per handshake, already in coding order, with a marker on the first coefficient of each block. Blocks are taken in macroblock order, six per macroblock, and the tokenizer handles each block on its own. No state crosses a block boundary.

For every nonzero coefficient the block emits one value token. That token carries the number of zero coefficients seen since the previous nonzero coefficient, or since the start of the block. Zeros after the last nonzero coefficient become a single end-of-block token. Every block is closed by exactly one such token, and that token also reports how many tokens the block produced. An end-of-block run therefore never covers more than one block, and a single pass in macroblock order is enough. The token output uses a valid/ready handshake. While the output is stalled, the coefficient input is held off, so no coefficient is lost.

Top module: `coef_tokenizer`

## Requirements
- R1: A block is exactly 64 coefficients. The coefficient accepted with `in_first` high is position 0, and the block closes after position 63 is accepted.
- R2: A value token has bit 18 = 0, bits [17:12] = the number of zero coefficients since the previous nonzero one in the same block (or since position 0), and bits [11:0] = the nonzero two's-complement coefficient.
- R3: An end-of-block token has bit 18 = 1 and bits [17:0] all zero.
- R4: Each block yields its value tokens in position order, followed by exactly one end-of-block token. Trailing zeros produce no further token.
- R5: A block whose 64 coefficients are all zero yields only one end-of-block token, with a count of 1.
- R6: When position 63 is nonzero, its value token is still followed by an end-of-block token.
- R7: `tok_count` is 0 on value tokens. On the end-of-block token it equals the number of tokens of that block, including the end-of-block token itself (1 to 65).
- R8: While `tok_valid` is high and `tok_ready` is low, `tok_word` and `tok_count` hold their values and `in_ready` is low. Every accepted coefficient is accounted for in the tokens.
- R9: After reset, `tok_valid` is low and `in_ready` is high.
- R10: Tokens leave in the order in which their blocks arrived. No token from one block appears after the end-of-block token of a later block, and no extra token is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Coefficient offered |
| in_ready | output | 1 | Coefficient will be accepted at this edge |
| in_first | input | 1 | Offered coefficient is position 0 of a block |
| in_coef | input | 12 | Quantized coefficient, two's complement |
| tok_valid | output | 1 | Token offered |
| tok_ready | input | 1 | Consumer takes the token at this edge |
| tok_word | output | 19 | Token: type bit, zero-run field, value field |
| tok_count | output | 7 | Tokens in the block, valid on the end-of-block token |

## Verification
Wrong position or run state shows up on the very next token. A run counter that is off by one corrupts bits [17:12] of the next value token. A position counter that is off moves the end-of-block token one coefficient early or late, and every token of the following block is then wrong. A lost pending end-of-block after a nonzero last coefficient merges two blocks at their boundary. A wrong token count appears only once per block, on the end-of-block token. The bench runs blocks with a single nonzero coefficient at every one of the 64 positions, blocks that are all zero or all nonzero, extreme values and mixed patterns, first with a free-running consumer and then under pseudo-random stalls and input gaps.

// File: rtl/coef_tok_pkg.sv
package coef_tok_pkg;

   // what the scan stage asks the output stage to do in one cycle
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_VALUE = 2'd1,
      ACT_EOB   = 2'd2
   } tok_act_e;

   function automatic int unsigned tok_width(int unsigned coef_w, int unsigned run_w);
      return 1 + run_w + coef_w;
   endfunction

endpackage

// File: rtl/tok_scan_ctrl.sv
module tok_scan_ctrl
   import coef_tok_pkg::*;
#(
   parameter int unsigned COEF_W        = 12,
   parameter int unsigned COEFS_PER_BLK = 64,
   localparam int unsigned RUN_W        = $clog2(COEFS_PER_BLK),
   localparam int unsigned CNT_W        = $clog2(COEFS_PER_BLK + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_first,
   input  logic [COEF_W-1:0] in_coef,
   input  logic              slot_free,
   output logic              in_ready,
   output tok_act_e          act,
   output logic [RUN_W-1:0]  act_run,
   output logic [CNT_W-1:0]  act_count
);

   localparam logic [RUN_W-1:0] LAST_POS = RUN_W'(COEFS_PER_BLK - 1);

   logic [RUN_W-1:0] pos_q, zrun_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;

   logic             take, nonzero, at_last;
   logic [RUN_W-1:0] pos_eff, zrun_eff;
   logic [CNT_W-1:0] cnt_eff;

   always_comb begin
      in_ready  = slot_free && !pend_q;
      take      = in_valid && in_ready;
      pos_eff   = in_first ? '0 : pos_q;
      zrun_eff  = in_first ? '0 : zrun_q;
      cnt_eff   = in_first ? '0 : cnt_q;
      nonzero   = |in_coef;
      at_last   = (pos_eff == LAST_POS);
      act       = ACT_NONE;
      act_run   = '0;
      act_count = '0;
      if (pend_q && slot_free) begin
         act       = ACT_EOB;
         act_count = cnt_q + 1'b1;
      end else if (take) begin
         if (nonzero) begin
            act     = ACT_VALUE;
            act_run = zrun_eff;
         end else if (at_last) begin
            act       = ACT_EOB;
            act_count = cnt_eff + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         zrun_q <= '0;
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (pend_q && slot_free) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (take) begin
         pos_q <= at_last ? '0 : pos_eff + 1'b1;
         if (nonzero) begin
            zrun_q <= '0;
            cnt_q  <= cnt_eff + 1'b1;
            pend_q <= at_last;
         end else begin
            zrun_q <= at_last ? '0 : zrun_eff + 1'b1;
            cnt_q  <= at_last ? '0 : cnt_eff;
         end
      end
   end

endmodule

// File: rtl/tok_out_stage.sv
module tok_out_stage #(
   parameter int unsigned TOK_W = 19,
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TOK_W-1:0] word_in,
   input  logic [CNT_W-1:0] count_in,
   input  logic             tok_ready,
   output logic             slot_free,
   output logic             tok_valid,
   output logic [TOK_W-1:0] tok_word,
   output logic [CNT_W-1:0] tok_count
);

   assign slot_free = !tok_valid || tok_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tok_valid <= 1'b0;
         tok_word  <= '0;
         tok_count <= '0;
      end else if (slot_free) begin
         tok_valid <= load;
         if (load) begin
            tok_word  <= word_in;
            tok_count <= count_in;
         end
      end
   end

endmodule

// File: rtl/coef_tokenizer.sv
module coef_tokenizer
   import coef_tok_pkg::*;
#(
   parameter int unsigned COEF_W        = 12,
   parameter int unsigned COEFS_PER_BLK = 64,
   localparam int unsigned RUN_W        = $clog2(COEFS_PER_BLK),
   localparam int unsigned CNT_W        = $clog2(COEFS_PER_BLK + 2),
   localparam int unsigned TOK_W        = 1 + RUN_W + COEF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_first,
   input  logic [COEF_W-1:0] in_coef,
   output logic              tok_valid,
   input  logic              tok_ready,
   output logic [TOK_W-1:0]  tok_word,
   output logic [CNT_W-1:0]  tok_count
);

   generate
      if (COEFS_PER_BLK < 2 || (COEFS_PER_BLK & (COEFS_PER_BLK - 1)) != 0) begin : g_bad_blk
         $error("coef_tokenizer: COEFS_PER_BLK must be a power of two of at least 2");
      end
      if (COEF_W < 2) begin : g_bad_coef
         $error("coef_tokenizer: COEF_W must be at least 2");
      end
      if (TOK_W != tok_width(COEF_W, RUN_W)) begin : g_bad_tok
         $error("coef_tokenizer: token width mismatch");
      end
   endgenerate

   tok_act_e         act;
   logic [RUN_W-1:0] act_run;
   logic [CNT_W-1:0] act_count;
   logic             slot_free;
   logic [TOK_W-1:0] word_next;

   tok_scan_ctrl #(
      .COEF_W        (COEF_W),
      .COEFS_PER_BLK (COEFS_PER_BLK)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_first  (in_first),
      .in_coef   (in_coef),
      .slot_free (slot_free),
      .in_ready  (in_ready),
      .act       (act),
      .act_run   (act_run),
      .act_count (act_count)
   );

   always_comb begin
      unique case (act)
         ACT_VALUE: word_next = {1'b0, act_run, in_coef};
         ACT_EOB:   word_next = {1'b1, {(TOK_W-1){1'b0}}};
         default:   word_next = '0;
      endcase
   end

   tok_out_stage #(
      .TOK_W (TOK_W),
      .CNT_W (CNT_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (act != ACT_NONE),
      .word_in   (word_next),
      .count_in  (act_count),
      .tok_ready (tok_ready),
      .slot_free (slot_free),
      .tok_valid (tok_valid),
      .tok_word  (tok_word),
      .tok_count (tok_count)
   );

endmodule

// File: rtl/coef_tok_checker.sv
module coef_tok_checker #(
   parameter int unsigned COEF_W        = 12,
   parameter int unsigned COEFS_PER_BLK = 64,
   localparam int unsigned RUN_W        = $clog2(COEFS_PER_BLK),
   localparam int unsigned CNT_W        = $clog2(COEFS_PER_BLK + 2),
   localparam int unsigned TOK_W        = 1 + RUN_W + COEF_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_ready,
   input logic             tok_valid,
   input logic             tok_ready,
   input logic [TOK_W-1:0] tok_word,
   input logic [CNT_W-1:0] tok_count
);

   localparam logic [CNT_W-1:0] MAX_TOK = CNT_W'(COEFS_PER_BLK + 1);

   logic is_eob;
   assign is_eob = tok_word[TOK_W-1];

   AST_EOB_FIELDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && is_eob |-> tok_word[TOK_W-2:0] == '0); // R3

   AST_VALUE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !is_eob |-> tok_word[COEF_W-1:0] != '0); // R2

   AST_VALUE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !is_eob |-> tok_count == '0); // R7

   AST_EOB_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && is_eob |-> tok_count != '0 && tok_count <= MAX_TOK); // R7

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !tok_ready |=> tok_valid && $stable(tok_word) && $stable(tok_count)); // R8

   AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !tok_ready |-> !in_ready); // R8

endmodule

bind coef_tokenizer coef_tok_checker #(
   .COEF_W        (COEF_W),
   .COEFS_PER_BLK (COEFS_PER_BLK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .tok_valid (tok_valid),
   .tok_ready (tok_ready),
   .tok_word  (tok_word),
   .tok_count (tok_count)
);

// File: tb/sim_coef_tokenizer.sv
module sim_coef_tokenizer;

   localparam int CLK_PERIOD = 10;
   localparam int NCOEF      = 64;
   localparam int NBLK       = 72;   // twelve macroblocks of six blocks
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_ready, in_first;
   logic [11:0] in_coef;
   logic        tok_valid, tok_ready;
   logic [18:0] tok_word;
   logic [6:0]  tok_count;

   coef_tokenizer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_first  (in_first),
      .in_coef   (in_coef),
      .tok_valid (tok_valid),
      .tok_ready (tok_ready),
      .tok_word  (tok_word),
      .tok_count (tok_count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          checks = 0;
   int          fails  = 0;
   logic [25:0] expq[$];     // {word, count}
   string       tagq[$];
   logic        stress = 1'b0;
   logic        running = 1'b0;
   logic [15:0] lfsr_o = 16'hACE1;
   logic [15:0] lfsr_i = 16'h1D2B;
   int          cycles = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   function automatic logic [11:0] coef_of(int b, int k);
      int v;
      if (b == 0) return 12'd0;
      if (b <= 64) return (k == b - 1) ? ((b % 2) ? 12'(-b) : 12'(b)) : 12'd0;
      if (b == 65) begin
         if (k == 0) return 12'h800;
         if (k == 1) return 12'h7FF;
         return (k % 2) ? 12'(k + 1) : 12'(-(k + 1));
      end
      if (b == 66) return (k == 0 || k == 40) ? 12'd300 : 12'd0;
      v = (k * 13 + b * 7) % 11;
      return (v < 4) ? 12'(v * 100 - 199) : 12'd0;
   endfunction

   task automatic push_block(int b);
      int run = 0;
      int cnt = 0;
      logic [11:0] c;
      for (int k = 0; k < NCOEF; k++) begin
         c = coef_of(b, k);
         if (c != 0) begin
            expq.push_back({1'b0, 6'(run), c, 7'd0});
            tagq.push_back((k == NCOEF - 1) ? "R6" : "R2");
            cnt++;
            run = 0;
         end else begin
            run++;
         end
      end
      expq.push_back({1'b1, 18'd0, 7'(cnt + 1)});
      tagq.push_back((cnt == 0) ? "R5" : "R1 R4 R7");
   endtask

   task automatic send(input logic [11:0] c, input logic first);
      bit ok;
      if (stress && lfsr_i[1] && lfsr_i[4]) begin
         in_valid = 1'b0;
         @(negedge clk); #1;
      end
      lfsr_i   = {lfsr_i[14:0], lfsr_i[15] ^ lfsr_i[13] ^ lfsr_i[12] ^ lfsr_i[10]};
      in_valid = 1'b1;
      in_coef  = c;
      in_first = first;
      forever begin
         ok = in_ready;
         @(negedge clk); #1;
         if (ok) break;
      end
      in_valid = 1'b0;
      in_first = 1'b0;
   endtask

   // consumer: decide readiness at the falling edge, inspect after settling
   logic        prev_stall = 1'b0;
   logic [25:0] prev_tok;
   initial begin
      tok_ready = 1'b1;
      forever begin
         @(negedge clk);
         if (running) begin
            lfsr_o    = {lfsr_o[14:0], lfsr_o[15] ^ lfsr_o[13] ^ lfsr_o[12] ^ lfsr_o[10]};
            tok_ready = stress ? (lfsr_o[0] | lfsr_o[3]) : 1'b1;
         end
         #1;
         if (running) begin
            if (prev_stall)
               check(tok_valid && {tok_word, tok_count} == prev_tok, "R8 held token",
                     {5'd0, tok_valid, tok_word, tok_count}, {6'd0, prev_tok});
            if (tok_valid && !tok_ready)
               check(!in_ready, "R8 input blocked", 32'(in_ready), 32'd0);
            if (tok_valid && tok_ready) begin
               if (expq.size() == 0) begin
                  check(1'b0, "R10 unexpected token", {6'd0, tok_word, tok_count}, 32'd0);
               end else begin
                  logic [25:0] e;
                  string t;
                  e = expq.pop_front();
                  t = tagq.pop_front();
                  check({tok_word, tok_count} == e, t, {6'd0, tok_word, tok_count}, {6'd0, e});
                  if (tok_word[18])
                     check(tok_word[17:0] == 18'd0, "R3 eob fields", 32'(tok_word[17:0]), 32'd0);
               end
            end
            prev_stall = tok_valid && !tok_ready;
            prev_tok   = {tok_word, tok_count};
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         check(1'b0, "R10 watchdog expired", 32'(cycles), 32'(WATCHDOG));
         finish_run();
      end
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_first = 1'b0;
      in_coef  = '0;
      repeat (3) @(negedge clk);
      #1;
      check(!tok_valid, "R9 tok_valid in reset", 32'(tok_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(!tok_valid && in_ready, "R9 idle after reset",
            {30'd0, tok_valid, in_ready}, 32'd1);
      running = 1'b1;
      for (int pass = 0; pass < 2; pass++) begin
         stress = (pass == 1);
         for (int b = 0; b < NBLK; b++) begin
            if (pass == 1 && b > 0 && b < 60 && (b % 5) != 0) continue;
            push_block(b);
            for (int k = 0; k < NCOEF; k++) send(coef_of(b, k), k == 0);
         end
      end
      for (int w = 0; w < 2000 && expq.size() != 0; w++) @(negedge clk);
      repeat (20) @(negedge clk);
      #2;
      check(expq.size() == 0, "R10 all tokens delivered", 32'(expq.size()), 32'd0);
      check(!tok_valid, "R10 no trailing token", 32'(tok_valid), 32'd0);
      finish_run();
   end

endmodule